// File: doc/BRIEF.md
# Four-Lane Vector Multiply-Accumulate Unit

This block is the arithmetic core of a fixed-point vector engine. It takes two 128-bit operand vectors, each holding eight signed 16-bit elements, and folds them into one 160-bit accumulator. The accumulator is 32 bits wider than the operand data, and those extra bits act as guard bits. The opcode chooses how the accumulator is split into lanes:

- For multiply-accumulate work it is four 40-bit lanes. Each lane takes the product of one pair of even-position elements.
- For add/subtract work it is eight 20-bit lanes. Each lane takes one element position from both operands.

An operation is offered with `in_valid` and runs through two register stages. The first stage forms the products or the element sums. The second stage adds them into the accumulator. A new operation can be accepted on every cycle. Surrounding logic can load the accumulator through a write port and can watch it at any time through a read port.

Top module: `vmac_unit`

## Requirements
- R1: While `rst` is high at a rising edge, the accumulator is zeroed and `out_valid` is driven low.
- R2: `out_valid` is high in exactly the cycles that follow the second rising edge after a cycle in which `in_valid` was sampled high. The accumulator already shows that operation's result in the same cycle.
- R3: Opcode 0 (multiply-add) works on each lane k from 0 to 3. It adds the signed product of `opnd_a[32k+15:32k]` and `opnd_b[32k+15:32k]`, sign-extended to 40 bits, to accumulator bits [40k+39:40k], modulo 2^40.
- R4: Opcode 1 (multiply-subtract) subtracts that same product from each 40-bit lane, modulo 2^40.
- R5: In opcodes 0 and 1, the odd-position elements (bits [32k+31:32k+16] of either operand) have no effect on the accumulator.
- R6: No carry or borrow crosses a lane boundary. This holds between the 40-bit lanes under opcodes 0 and 1, and between the 20-bit lanes under opcodes 3 and 4.
- R7: Opcode 2 (clear) sets all 160 accumulator bits to zero.
- R8: Opcode 3 (lane add) works on each 20-bit lane j from 0 to 7 (bits [20j+19:20j]). It adds the sign-extended element `opnd_a[16j+15:16j]` and the sign-extended element `opnd_b[16j+15:16j]` to that lane, modulo 2^20.
- R9: Opcode 4 (lane subtract) subtracts both of those sign-extended elements from each 20-bit lane, modulo 2^20.
- R10: Opcodes 5, 6 and 7 leave the accumulator unchanged. So does any input cycle with `in_valid` low.
- R11: When `acc_wr_en` is high at a rising edge, the accumulator takes `acc_wr_data` at that edge. The write overrides any operation that reaches the accumulate stage on the same edge.
- R12: Operations issued on back-to-back cycles are all applied, in issue order, with no stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation offered this cycle |
| in_op | input | 3 | Opcode: 0 mul-add, 1 mul-sub, 2 clear, 3 lane add, 4 lane subtract, 5-7 no effect |
| opnd_a | input | 128 | First operand vector, eight signed 16-bit elements |
| opnd_b | input | 128 | Second operand vector, eight signed 16-bit elements |
| acc_wr_en | input | 1 | Load the accumulator from `acc_wr_data` |
| acc_wr_data | input | 160 | Value to load into the accumulator |
| acc_rd_data | output | 160 | Current accumulator contents |
| out_valid | output | 1 | An operation's result was written this cycle |

## Verification
The assertions assume that every input carries a defined 0/1 value at each rising edge. They also assume that `in_valid` is held low while reset is active, so no operation is in flight when reset is released. A write and an arriving operation may land on the same edge; the properties accept this and expect the write to win. The stimulus changes every input only on the falling edge and keeps `in_valid` low throughout reset. It issues write-plus-operation collisions on purpose, so the write-priority property is exercised and not only assumed.

// File: rtl/vmac_pkg.sv
package vmac_pkg;
    parameter int N_MAC   = 4;
    parameter int ELEM_W  = 16;
    parameter int GUARD_W = 8;

    localparam int PROD_W = 2 * ELEM_W;
    localparam int MAC_W  = PROD_W + GUARD_W;
    localparam int N_ALU  = 2 * N_MAC;
    localparam int ALU_W  = MAC_W / 2;
    localparam int VEC_W  = N_ALU * ELEM_W;
    localparam int ACC_W  = N_MAC * MAC_W;

    typedef enum logic [2:0] {
        OP_MAC  = 3'd0,
        OP_MSUB = 3'd1,
        OP_CLR  = 3'd2,
        OP_ADD  = 3'd3,
        OP_SUB  = 3'd4,
        OP_RSV5 = 3'd5,
        OP_RSV6 = 3'd6,
        OP_RSV7 = 3'd7
    } vop_e;

    typedef struct packed {
        logic                          valid;
        vop_e                          op;
        logic [N_MAC-1:0][MAC_W-1:0]   prod;
        logic [N_ALU-1:0][ALU_W-1:0]   addend;
    } stage1_t;

    function automatic logic [MAC_W-1:0] widen_prod(input logic [PROD_W-1:0] p);
        return {{GUARD_W{p[PROD_W-1]}}, p};
    endfunction

    function automatic logic [ALU_W-1:0] widen_elem(input logic [ELEM_W-1:0] e);
        return {{(ALU_W-ELEM_W){e[ELEM_W-1]}}, e};
    endfunction
endpackage

// File: rtl/vmac_front.sv
module vmac_front
    import vmac_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [2:0]       in_op,
    input  logic [VEC_W-1:0] opnd_a,
    input  logic [VEC_W-1:0] opnd_b,
    output stage1_t          s1
);
    logic [N_MAC-1:0][MAC_W-1:0] prod_w;
    logic [N_ALU-1:0][ALU_W-1:0] sum_w;

    for (genvar k = 0; k < N_MAC; k++) begin : g_mul
        logic signed [ELEM_W-1:0] ea;
        logic signed [ELEM_W-1:0] eb;
        logic signed [PROD_W-1:0] p;
        assign ea        = opnd_a[2*k*ELEM_W +: ELEM_W];
        assign eb        = opnd_b[2*k*ELEM_W +: ELEM_W];
        assign p         = ea * eb;
        assign prod_w[k] = widen_prod(p);
    end

    for (genvar j = 0; j < N_ALU; j++) begin : g_sum
        assign sum_w[j] = widen_elem(opnd_a[j*ELEM_W +: ELEM_W])
                        + widen_elem(opnd_b[j*ELEM_W +: ELEM_W]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s1 <= '0;
        end else begin
            s1.valid <= in_valid;
            if (in_valid) begin
                s1.op     <= vop_e'(in_op);
                s1.prod   <= prod_w;
                s1.addend <= sum_w;
            end
        end
    end

    AST_FRONT_TAKE: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> s1.valid); // R2
    AST_FRONT_IDLE: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !s1.valid); // R2
endmodule

// File: rtl/vmac_accum.sv
module vmac_accum
    import vmac_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  stage1_t          s1,
    input  logic             acc_wr_en,
    input  logic [ACC_W-1:0] acc_wr_data,
    output logic [ACC_W-1:0] acc,
    output logic             out_valid
);
    logic [ACC_W-1:0] mac_add, mac_sub, alu_add, alu_sub, acc_nxt;

    for (genvar k = 0; k < N_MAC; k++) begin : g_mac_lane
        assign mac_add[k*MAC_W +: MAC_W] = acc[k*MAC_W +: MAC_W] + s1.prod[k];
        assign mac_sub[k*MAC_W +: MAC_W] = acc[k*MAC_W +: MAC_W] - s1.prod[k];
    end

    for (genvar j = 0; j < N_ALU; j++) begin : g_alu_lane
        assign alu_add[j*ALU_W +: ALU_W] = acc[j*ALU_W +: ALU_W] + s1.addend[j];
        assign alu_sub[j*ALU_W +: ALU_W] = acc[j*ALU_W +: ALU_W] - s1.addend[j];
    end

    always_comb begin
        acc_nxt = acc;
        if (acc_wr_en) begin
            acc_nxt = acc_wr_data;
        end else if (s1.valid) begin
            case (s1.op)
                OP_MAC:  acc_nxt = mac_add;
                OP_MSUB: acc_nxt = mac_sub;
                OP_CLR:  acc_nxt = '0;
                OP_ADD:  acc_nxt = alu_add;
                OP_SUB:  acc_nxt = alu_sub;
                default: acc_nxt = acc;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc       <= '0;
            out_valid <= 1'b0;
        end else begin
            acc       <= acc_nxt;
            out_valid <= s1.valid;
        end
    end

    AST_RESULT_FLAG: assert property (@(posedge clk) disable iff (rst)
        s1.valid |=> out_valid); // R2
    AST_RESULT_QUIET: assert property (@(posedge clk) disable iff (rst)
        !s1.valid |=> !out_valid); // R2
    AST_CLEAR_ALL: assert property (@(posedge clk) disable iff (rst)
        (s1.valid && s1.op == OP_CLR && !acc_wr_en) |=> (acc == '0)); // R7
    AST_WRITE_WINS: assert property (@(posedge clk) disable iff (rst)
        acc_wr_en |=> (acc == $past(acc_wr_data))); // R11
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!acc_wr_en && (!s1.valid || s1.op inside {OP_RSV5, OP_RSV6, OP_RSV7}))
        |=> $stable(acc)); // R10
endmodule

// File: rtl/vmac_unit.sv
module vmac_unit
    import vmac_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [2:0]       in_op,
    input  logic [VEC_W-1:0] opnd_a,
    input  logic [VEC_W-1:0] opnd_b,
    input  logic             acc_wr_en,
    input  logic [ACC_W-1:0] acc_wr_data,
    output logic [ACC_W-1:0] acc_rd_data,
    output logic             out_valid
);
    stage1_t          s1;
    logic [ACC_W-1:0] acc;

    vmac_front u_front (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_op    (in_op),
        .opnd_a   (opnd_a),
        .opnd_b   (opnd_b),
        .s1       (s1)
    );

    vmac_accum u_accum (
        .clk         (clk),
        .rst         (rst),
        .s1          (s1),
        .acc_wr_en   (acc_wr_en),
        .acc_wr_data (acc_wr_data),
        .acc         (acc),
        .out_valid   (out_valid)
    );

    assign acc_rd_data = acc;
endmodule

// File: tb/vmac_unit_bench.sv
module vmac_unit_bench;
    import vmac_pkg::*;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             in_valid = 1'b0;
    logic [2:0]       in_op = 3'd0;
    logic [VEC_W-1:0] opnd_a = '0;
    logic [VEC_W-1:0] opnd_b = '0;
    logic             acc_wr_en = 1'b0;
    logic [ACC_W-1:0] acc_wr_data = '0;
    logic [ACC_W-1:0] acc_rd_data;
    logic             out_valid;

    always #10 clk = ~clk;

    vmac_unit u_vmac_unit (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .acc_wr_en(acc_wr_en),
        .acc_wr_data(acc_wr_data), .acc_rd_data(acc_rd_data), .out_valid(out_valid)
    );

    int    checks = 0;
    int    fails  = 0;
    string tag    = "R1";
    logic  done   = 1'b0;

    logic [ACC_W-1:0] ref_acc = '0;
    logic             ref_ov  = 1'b0;
    logic             pv      = 1'b0;
    logic [2:0]       pop     = 3'd0;
    logic [VEC_W-1:0] pa      = '0;
    logic [VEC_W-1:0] pb      = '0;

    function automatic logic [ACC_W-1:0] model_op(input logic [ACC_W-1:0] acc,
            input logic [2:0] op, input logic [VEC_W-1:0] a, input logic [VEC_W-1:0] b);
        logic [ACC_W-1:0] r = acc;
        case (op)
            3'd0, 3'd1: begin
                for (int k = 0; k < 4; k++) begin
                    longint x = $signed(a[32*k +: 16]);
                    longint y = $signed(b[32*k +: 16]);
                    longint cur = acc[40*k +: 40];
                    longint t = (op == 3'd0) ? cur + x * y : cur - x * y;
                    r[40*k +: 40] = t[39:0];
                end
            end
            3'd2: r = '0;
            3'd3, 3'd4: begin
                for (int j = 0; j < 8; j++) begin
                    longint x = $signed(a[16*j +: 16]);
                    longint y = $signed(b[16*j +: 16]);
                    longint cur = acc[20*j +: 20];
                    longint t = (op == 3'd3) ? cur + x + y : cur - x - y;
                    r[20*j +: 20] = t[19:0];
                end
            end
            default: r = acc;
        endcase
        return r;
    endfunction

    task automatic compare();
        checks++;
        if (acc_rd_data !== ref_acc) begin
            fails++;
            $display("FAIL %s acc actual=%h expected=%h", tag, acc_rd_data, ref_acc);
        end
        checks++;
        if (out_valid !== ref_ov) begin
            fails++;
            $display("FAIL R2 out_valid actual=%b expected=%b", out_valid, ref_ov);
        end
    endtask

    task automatic cycle(input logic v, input logic [2:0] op, input logic [VEC_W-1:0] a,
                         input logic [VEC_W-1:0] b, input logic we, input logic [ACC_W-1:0] wd);
        logic [ACC_W-1:0] nxt;
        in_valid = v; in_op = op; opnd_a = a; opnd_b = b;
        acc_wr_en = we; acc_wr_data = wd;
        nxt = pv ? model_op(ref_acc, pop, pa, pb) : ref_acc;
        if (we) nxt = wd;
        ref_acc = nxt;
        ref_ov  = pv;
        pv = v; pop = op; pa = a; pb = b;
        @(posedge clk);
        @(negedge clk);
        compare();
    endtask

    task automatic issue(input logic [2:0] op, input logic [VEC_W-1:0] a, input logic [VEC_W-1:0] b);
        cycle(1'b1, op, a, b, 1'b0, '0);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cycle(1'b0, 3'd0, '0, '0, 1'b0, '0);
    endtask

    task automatic load(input logic [ACC_W-1:0] d);
        cycle(1'b0, 3'd0, '0, '0, 1'b1, d);
    endtask

    function automatic logic [VEC_W-1:0] rnd_vec();
        return {$urandom, $urandom, $urandom, $urandom};
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL R12 watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        tag = "R1";
        compare();
        rst = 1'b0;

        tag = "R3";
        issue(3'd0, {8{16'h0003}}, {8{16'h0005}});
        issue(3'd0, {16'h0, 16'h7FFF, 16'h0, 16'h8000, 16'h0, 16'hFFFF, 16'h0, 16'h1234},
                    {16'h0, 16'h7FFF, 16'h0, 16'h8000, 16'h0, 16'h0002, 16'h0, 16'hFFF0});
        idle(2);

        tag = "R4";
        issue(3'd1, {8{16'hFFF9}}, {8{16'h0101}});
        issue(3'd1, {8{16'h8000}}, {8{16'h8000}});
        idle(2);

        tag = "R5";
        issue(3'd0, {16'h1111, 16'h0, 16'h2222, 16'h0, 16'h3333, 16'h0, 16'h4444, 16'h0},
                    {16'h5555, 16'h0007, 16'h6666, 16'h0007, 16'h7777, 16'h0007, 16'h8888, 16'h0007});
        idle(2);
        issue(3'd1, {16'hABCD, 16'h0002, 16'h9876, 16'h0002, 16'h4321, 16'h0002, 16'hFEDC, 16'h0002},
                    {16'h1357, 16'h0003, 16'h2468, 16'h0003, 16'hACE0, 16'h0003, 16'hBDF1, 16'h0003});
        idle(2);

        tag = "R6";
        load({40'h0, 40'h00_0001_2345, 40'h7F_FFFF_FFFF, 40'hFF_FFFF_FFFF});
        issue(3'd0, {8{16'h0001}}, {8{16'h0001}});
        idle(2);
        load('0);
        issue(3'd1, {8{16'h0001}}, {8{16'h0001}});
        idle(2);
        load({8{20'hFFFFF}});
        issue(3'd3, {8{16'h0001}}, {8{16'h0000}});
        idle(2);
        issue(3'd4, {8{16'h0000}}, {8{16'h0001}});
        idle(2);

        tag = "R7";
        load({5{32'hDEAD_BEEF}});
        issue(3'd2, rnd_vec(), rnd_vec());
        idle(2);

        tag = "R8";
        issue(3'd3, {16'h7FFF, 16'h8000, 16'hFFFF, 16'h0001, 16'h1234, 16'hEDCC, 16'h0100, 16'h7FFF},
                    {16'h7FFF, 16'h8000, 16'h0005, 16'hFFFF, 16'h1111, 16'h2222, 16'hFF00, 16'h0001});
        issue(3'd3, rnd_vec(), rnd_vec());
        idle(2);

        tag = "R9";
        issue(3'd4, {8{16'h8000}}, {8{16'h8000}});
        issue(3'd4, rnd_vec(), rnd_vec());
        idle(2);

        tag = "R10";
        load({5{32'h0123_4567}});
        issue(3'd5, rnd_vec(), rnd_vec());
        issue(3'd6, rnd_vec(), rnd_vec());
        issue(3'd7, rnd_vec(), rnd_vec());
        cycle(1'b0, 3'd0, rnd_vec(), rnd_vec(), 1'b0, '0);
        cycle(1'b0, 3'd3, rnd_vec(), rnd_vec(), 1'b0, '0);
        idle(2);

        tag = "R11";
        issue(3'd0, {8{16'h0100}}, {8{16'h0100}});
        load({5{32'hCAFE_F00D}});
        idle(1);
        issue(3'd2, '0, '0);
        cycle(1'b0, 3'd0, '0, '0, 1'b1, {5{32'h0F0F_0F0F}});
        idle(2);

        tag = "R12";
        for (int i = 0; i < 600; i++) begin
            logic we = ($urandom % 16) == 0;
            logic [ACC_W-1:0] wd = {$urandom, $urandom, $urandom, $urandom, $urandom};
            cycle(($urandom % 8) != 0, 3'($urandom % 8), rnd_vec(), rnd_vec(), we, wd);
        end
        for (int i = 0; i < 100; i++) issue(3'($urandom % 5), rnd_vec(), rnd_vec());
        idle(3);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule